// File: doc/BRIEF.md
# UART Control, Status and Interrupt Register Block

This block is the software-visible face of a UART. It sits on a simple 32-bit register bus and stores the settings that drive the serial datapath: mode select, character format, baud divider and pin routing. A write-only command word starts and stops the receiver and the transmitter. A status word shows live conditions reported by the datapath. A bank of interrupt flags collects transmit and receive events, and a mask folds the flags into one interrupt line. The shifters and the baud generator are outside this block. They consume the configuration outputs and feed back event pulses and status levels.

Each direction is enabled by a small two-state machine with the states `EN_OFF` and `EN_ON`. The transition `EN_OFF -> EN_ON` happens on a start strobe that has no stop strobe in the same word. The transition `EN_ON -> EN_OFF` happens on any stop strobe. In every other case the machine stays in its state. Flags are either sticky, meaning set by an event or a set-write and cleared by a clear-write, or live, meaning they follow a status level.

Bus writes take effect at the clock edge. Reads are combinational from the current state.

Top module: `uart_csr_block`

## Requirements
- R1: After reset every stored register reads zero, both enables are low and `irq` is low.
- R2: Writable registers keep only their implemented bits and read them back; other bits read zero. The mode word at 0x00 keeps bit0 (synchronous mode) and bit12 (half-empty level select). The format word at 0x04 keeps bits 3:0 (data bits), 9:8 (parity) and 13:12 (stop). The divider word at 0x14 keeps bits 20:6. The pin word at 0x54 keeps bit0 (RX pin), bit1 (TX pin) and bits 10:8 (location). Each field appears on its output port.
- R3: A write to the command word at 0x0C uses bit0 to start RX, bit1 to stop RX, bit2 to start TX and bit3 to stop TX. When start and stop for the same direction arrive together, stop wins. A zero bit leaves its direction unchanged, and the command word reads zero.
- R4: The status word at 0x10 shows bit0 RX enabled, bit1 TX enabled, bit5 transmit complete, bit6 TX buffer level and bit7 RX data available. Writes to it are ignored.
- R5: The TX buffer level is the half-empty input when mode bit12 is 1, and the empty input when mode bit12 is 0.
- R6: In the flag word at 0x40, bit0 is set by a TX-complete pulse, bit2 by an RX-data pulse and bit4 by an RX-overflow pulse. Each of these bits is set from the next cycle on and stays set. Bit3 reads zero.
- R7: Writing a one to the set word at 0x44 sets the corresponding sticky flag (bits 0, 2, 4). Writing a one to the clear word at 0x48 clears it.
- R8: When a hardware event and a clear-write hit the same flag in the same cycle, the flag stays set.
- R9: Flag bit1 always equals the TX buffer level. Set-writes and clear-writes do not affect it.
- R10: The mask word at 0x4C keeps bits 0, 1, 2 and 4. `irq` is high exactly when some flag bit and its mask bit are both one.
- R11: Reads of undefined offsets return zero, and writes to them change no register.
- R12: A write to 0x34 pulses `tx_push` in that cycle, with `tx_byte` equal to write data bits 8:0. A read of 0x18 returns `rx_word` in bits 15:0 and pulses `rx_pop` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| tx_idle_i | input | 1 | Transmitter has finished all frames |
| tx_empty_i | input | 1 | Transmit buffer is empty |
| tx_half_i | input | 1 | Transmit buffer is at most half full |
| rx_avail_i | input | 1 | Receive buffer holds data |
| tx_done_evt | input | 1 | Pulse: a transmission completed |
| rx_got_evt | input | 1 | Pulse: a character was received |
| rx_ovf_evt | input | 1 | Pulse: the receive buffer overflowed |
| rx_word | input | 16 | Received character and its error bits |
| rx_en | output | 1 | Receiver enable level |
| tx_en | output | 1 | Transmitter enable level |
| sync_mode | output | 1 | Synchronous mode select |
| frm_bits | output | 4 | Data-bit field |
| frm_par | output | 2 | Parity field |
| frm_stop | output | 2 | Stop field |
| baud_div | output | 15 | Baud divider field |
| pin_rx_en | output | 1 | RX pin enable |
| pin_tx_en | output | 1 | TX pin enable |
| pin_loc | output | 3 | Pin location code |
| tx_push | output | 1 | Transmit data write strobe |
| tx_byte | output | 9 | Transmit data |
| rx_pop | output | 1 | Receive data read strobe |
| irq | output | 1 | Masked interrupt request |

## Verification
The properties assume that the datapath inputs are known from reset onward and change only between clock edges. They also assume that an event pulse lasts whole cycles and that the bus issues at most one write per cycle. The bench drives every input on the falling edge and holds each event pulse for exactly one cycle. It raises an event together with a clear-write only in the collision scenario. It never leaves an address or data line unknown while a strobe is high.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_FMT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DIV  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_RXD  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_TXD  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_FLG  = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_FSET = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_FCLR = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_FMSK = 8'h4C;
    localparam logic [ADDR_W-1:0] OFS_PIN  = 8'h54;

    // mode word bits
    localparam int MODE_SYNC = 0;
    localparam int MODE_HALF = 12;

    // command strobe bits
    localparam int CMD_RX_ON  = 0;
    localparam int CMD_RX_OFF = 1;
    localparam int CMD_TX_ON  = 2;
    localparam int CMD_TX_OFF = 3;

    // status bits
    localparam int ST_RXEN = 0;
    localparam int ST_TXEN = 1;
    localparam int ST_IDLE = 5;
    localparam int ST_LVL  = 6;
    localparam int ST_RXAV = 7;

    // flag bits
    localparam int FLAG_W   = 5;
    localparam int FL_TXDN  = 0;
    localparam int FL_TXLVL = 1;
    localparam int FL_RXAV  = 2;
    localparam int FL_RXOVF = 4;
    localparam logic [FLAG_W-1:0] FLAG_STICKY = 5'b10101;
    localparam logic [FLAG_W-1:0] FLAG_LIVE   = 5'b00010;

    // field geometry
    localparam int FMT_BITS_LSB = 0;
    localparam int FMT_BITS_W   = 4;
    localparam int FMT_PAR_LSB  = 8;
    localparam int FMT_PAR_W    = 2;
    localparam int FMT_STOP_LSB = 12;
    localparam int FMT_STOP_W   = 2;
    localparam int DIV_LSB      = 6;
    localparam int DIV_W        = 15;
    localparam int PIN_RX       = 0;
    localparam int PIN_TX       = 1;
    localparam int PIN_LOC_LSB  = 8;
    localparam int PIN_LOC_W    = 3;
    localparam int TXB_W        = 9;
    localparam int RXW_W        = 16;

    localparam logic [REG_W-1:0] MODE_KEEP = (REG_W'(1) << MODE_SYNC) | (REG_W'(1) << MODE_HALF);
    localparam logic [REG_W-1:0] FMT_KEEP  =
        (((REG_W'(1) << FMT_BITS_W) - 1) << FMT_BITS_LSB) |
        (((REG_W'(1) << FMT_PAR_W)  - 1) << FMT_PAR_LSB)  |
        (((REG_W'(1) << FMT_STOP_W) - 1) << FMT_STOP_LSB);
    localparam logic [REG_W-1:0] DIV_KEEP  = ((REG_W'(1) << DIV_W) - 1) << DIV_LSB;
    localparam logic [REG_W-1:0] PIN_KEEP  =
        (REG_W'(1) << PIN_RX) | (REG_W'(1) << PIN_TX) |
        (((REG_W'(1) << PIN_LOC_W) - 1) << PIN_LOC_LSB);

    // configuration register table, entry 0 in the low slice
    localparam int NCFG     = 4;
    localparam int CFG_MODE = 0;
    localparam int CFG_FMT  = 1;
    localparam int CFG_DIV  = 2;
    localparam int CFG_PIN  = 3;
    localparam logic [NCFG*ADDR_W-1:0] CFG_OFS_PK  = {OFS_PIN, OFS_DIV, OFS_FMT, OFS_MODE};
    localparam logic [NCFG*REG_W-1:0]  CFG_KEEP_PK = {PIN_KEEP, DIV_KEEP, FMT_KEEP, MODE_KEEP};

    typedef enum logic [0:0] {
        EN_OFF = 1'b0,
        EN_ON  = 1'b1
    } en_state_e;

endpackage

// File: rtl/uart_mreg.sv
module uart_mreg #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   KEEP = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata & KEEP;
        end
    end

endmodule

// File: rtl/uart_en_fsm.sv
module uart_en_fsm
    import uart_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic on_req,
    input  logic off_req,
    output logic active
);

    en_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= EN_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    // stop has priority over start
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            EN_OFF: if (on_req && !off_req) st_d = EN_ON;
            EN_ON:  if (off_req)            st_d = EN_OFF;
        endcase
    end

    always_comb begin
        unique case (st_q)
            EN_OFF: active = 1'b0;
            EN_ON:  active = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_flag_bank.sv
module uart_flag_bank #(
    parameter int           W      = 5,
    parameter logic [W-1:0] STICKY = '0,
    parameter logic [W-1:0] LIVE   = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic         mask_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    input  logic [W-1:0] live,
    output logic [W-1:0] flags,
    output logic [W-1:0] mask,
    output logic         irq
);

    logic [W-1:0] sticky_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // set sources (event or set-write) beat the clear-write
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sticky_q[i] <= 1'b0;
            end else if (STICKY[i]) begin
                if (evt[i] || (set_we && wdata[i])) begin
                    sticky_q[i] <= 1'b1;
                end else if (clr_we && wdata[i]) begin
                    sticky_q[i] <= 1'b0;
                end
            end
        end

        assign flags[i] = LIVE[i]   ? live[i] :
                          STICKY[i] ? sticky_q[i] : 1'b0;
    end

    uart_mreg #(
        .W    (W),
        .KEEP (STICKY | LIVE)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mask_we),
        .wdata (wdata),
        .q     (mask)
    );

    assign irq = |(flags & mask);

endmodule

// File: rtl/uart_csr_block.sv
module uart_csr_block
    import uart_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              tx_idle_i,
    input  logic              tx_empty_i,
    input  logic              tx_half_i,
    input  logic              rx_avail_i,
    input  logic              tx_done_evt,
    input  logic              rx_got_evt,
    input  logic              rx_ovf_evt,
    input  logic [RXW_W-1:0]  rx_word,
    output logic              rx_en,
    output logic              tx_en,
    output logic              sync_mode,
    output logic [FMT_BITS_W-1:0] frm_bits,
    output logic [FMT_PAR_W-1:0]  frm_par,
    output logic [FMT_STOP_W-1:0] frm_stop,
    output logic [DIV_W-1:0]      baud_div,
    output logic              pin_rx_en,
    output logic              pin_tx_en,
    output logic [PIN_LOC_W-1:0]  pin_loc,
    output logic              tx_push,
    output logic [TXB_W-1:0]  tx_byte,
    output logic              rx_pop,
    output logic              irq
);

    logic [REG_W-1:0]  cfg_q [NCFG];
    logic              cmd_wr;
    logic              txlvl;
    logic [FLAG_W-1:0] flag_vec;
    logic [FLAG_W-1:0] mask_vec;
    logic [FLAG_W-1:0] evt_vec;
    logic [FLAG_W-1:0] live_vec;
    logic [REG_W-1:0]  stat_word;

    // configuration registers
    for (genvar g = 0; g < NCFG; g++) begin : g_cfg
        uart_mreg #(
            .W    (REG_W),
            .KEEP (CFG_KEEP_PK[g*REG_W +: REG_W])
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bus_wr && (bus_addr == CFG_OFS_PK[g*ADDR_W +: ADDR_W])),
            .wdata (bus_wdata),
            .q     (cfg_q[g])
        );
    end

    assign sync_mode = cfg_q[CFG_MODE][MODE_SYNC];
    assign frm_bits  = cfg_q[CFG_FMT][FMT_BITS_LSB +: FMT_BITS_W];
    assign frm_par   = cfg_q[CFG_FMT][FMT_PAR_LSB  +: FMT_PAR_W];
    assign frm_stop  = cfg_q[CFG_FMT][FMT_STOP_LSB +: FMT_STOP_W];
    assign baud_div  = cfg_q[CFG_DIV][DIV_LSB +: DIV_W];
    assign pin_rx_en = cfg_q[CFG_PIN][PIN_RX];
    assign pin_tx_en = cfg_q[CFG_PIN][PIN_TX];
    assign pin_loc   = cfg_q[CFG_PIN][PIN_LOC_LSB +: PIN_LOC_W];

    // command decode into per-direction enable machines
    assign cmd_wr = bus_wr && (bus_addr == OFS_CMD);

    uart_en_fsm u_rx_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_req  (cmd_wr && bus_wdata[CMD_RX_ON]),
        .off_req (cmd_wr && bus_wdata[CMD_RX_OFF]),
        .active  (rx_en)
    );

    uart_en_fsm u_tx_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .on_req  (cmd_wr && bus_wdata[CMD_TX_ON]),
        .off_req (cmd_wr && bus_wdata[CMD_TX_OFF]),
        .active  (tx_en)
    );

    // transmit buffer level: half-empty or empty
    assign txlvl = cfg_q[CFG_MODE][MODE_HALF] ? tx_half_i : tx_empty_i;

    always_comb begin
        stat_word          = '0;
        stat_word[ST_RXEN] = rx_en;
        stat_word[ST_TXEN] = tx_en;
        stat_word[ST_IDLE] = tx_idle_i;
        stat_word[ST_LVL]  = txlvl;
        stat_word[ST_RXAV] = rx_avail_i;
    end

    // interrupt flags
    always_comb begin
        evt_vec            = '0;
        evt_vec[FL_TXDN]   = tx_done_evt;
        evt_vec[FL_RXAV]   = rx_got_evt;
        evt_vec[FL_RXOVF]  = rx_ovf_evt;
        live_vec           = '0;
        live_vec[FL_TXLVL] = txlvl;
    end

    uart_flag_bank #(
        .W      (FLAG_W),
        .STICKY (FLAG_STICKY),
        .LIVE   (FLAG_LIVE)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_we  (bus_wr && (bus_addr == OFS_FSET)),
        .clr_we  (bus_wr && (bus_addr == OFS_FCLR)),
        .mask_we (bus_wr && (bus_addr == OFS_FMSK)),
        .wdata   (bus_wdata[FLAG_W-1:0]),
        .evt     (evt_vec),
        .live    (live_vec),
        .flags   (flag_vec),
        .mask    (mask_vec),
        .irq     (irq)
    );

    // data path strobes
    assign tx_push = bus_wr && (bus_addr == OFS_TXD);
    assign tx_byte = bus_wdata[TXB_W-1:0];
    assign rx_pop  = bus_rd && (bus_addr == OFS_RXD);

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE: bus_rdata = cfg_q[CFG_MODE];
            OFS_FMT:  bus_rdata = cfg_q[CFG_FMT];
            OFS_DIV:  bus_rdata = cfg_q[CFG_DIV];
            OFS_PIN:  bus_rdata = cfg_q[CFG_PIN];
            OFS_STAT: bus_rdata = stat_word;
            OFS_FLG:  bus_rdata = REG_W'(flag_vec);
            OFS_FMSK: bus_rdata = REG_W'(mask_vec);
            OFS_RXD:  bus_rdata = REG_W'(rx_word);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_csr_chk.sv
module uart_csr_chk
    import uart_csr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              rx_en,
    input logic              tx_en,
    input logic              tx_done_evt,
    input logic              rx_ovf_evt,
    input logic              lvl,
    input logic [FLAG_W-1:0] flags,
    input logic [FLAG_W-1:0] mask,
    input logic              irq
);

    logic c_cmd, c_set, c_clr;
    assign c_cmd = bus_wr && (bus_addr == OFS_CMD);
    assign c_set = bus_wr && (bus_addr == OFS_FSET);
    assign c_clr = bus_wr && (bus_addr == OFS_FCLR);

    assert_rx_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd && bus_wdata[CMD_RX_ON] && !bus_wdata[CMD_RX_OFF]) |=> rx_en);

    assert_rx_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd && bus_wdata[CMD_RX_OFF]) |=> !rx_en);

    assert_tx_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd && bus_wdata[CMD_TX_ON] && !bus_wdata[CMD_TX_OFF]) |=> tx_en);

    assert_tx_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_cmd && bus_wdata[CMD_TX_OFF]) |=> !tx_en);

    assert_en_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !c_cmd |=> ($stable(rx_en) && $stable(tx_en)));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[FL_RXAV] && !(c_clr && bus_wdata[FL_RXAV])) |=> flags[FL_RXAV]);

    assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_set && bus_wdata[FL_RXOVF]) |=> flags[FL_RXOVF]);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_clr && bus_wdata[FL_TXDN] && !tx_done_evt) |=> !flags[FL_TXDN]);

    assert_evt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf_evt |=> flags[FL_RXOVF]);

    assert_live_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flags[FL_TXLVL] == lvl);

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

endmodule

bind uart_csr_block uart_csr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .rx_en       (rx_en),
    .tx_en       (tx_en),
    .tx_done_evt (tx_done_evt),
    .rx_ovf_evt  (rx_ovf_evt),
    .lvl         (txlvl),
    .flags       (flag_vec),
    .mask        (mask_vec),
    .irq         (irq)
);

// File: tb/uart_csr_block_tb.sv
`timescale 1ns/1ps
module uart_csr_block_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_idle_i = 0, tx_empty_i = 0, tx_half_i = 0, rx_avail_i = 0;
    logic        tx_done_evt = 0, rx_got_evt = 0, rx_ovf_evt = 0;
    logic [15:0] rx_word = '0;
    logic        rx_en, tx_en, sync_mode, pin_rx_en, pin_tx_en, tx_push, rx_pop, irq;
    logic [3:0]  frm_bits;
    logic [1:0]  frm_par, frm_stop;
    logic [14:0] baud_div;
    logic [2:0]  pin_loc;
    logic [8:0]  tx_byte;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    uart_csr_block dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_idle_i(tx_idle_i), .tx_empty_i(tx_empty_i), .tx_half_i(tx_half_i),
        .rx_avail_i(rx_avail_i), .tx_done_evt(tx_done_evt), .rx_got_evt(rx_got_evt),
        .rx_ovf_evt(rx_ovf_evt), .rx_word(rx_word), .rx_en(rx_en), .tx_en(tx_en),
        .sync_mode(sync_mode), .frm_bits(frm_bits), .frm_par(frm_par),
        .frm_stop(frm_stop), .baud_div(baud_div), .pin_rx_en(pin_rx_en),
        .pin_tx_en(pin_tx_en), .pin_loc(pin_loc), .tx_push(tx_push),
        .tx_byte(tx_byte), .rx_pop(rx_pop), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 chk(req, bus_rdata, exp);
        bus_rd = 1'b0;
    endtask

    task automatic t_reset;
        rd_chk("R1 mode",   8'h00, 32'h0);
        rd_chk("R1 format", 8'h04, 32'h0);
        rd_chk("R1 status", 8'h10, 32'h0);
        rd_chk("R1 div",    8'h14, 32'h0);
        rd_chk("R1 flags",  8'h40, 32'h0);
        rd_chk("R1 mask",   8'h4C, 32'h0);
        rd_chk("R1 pins",   8'h54, 32'h0);
        chk("R1 enables/irq", {29'b0, rx_en, tx_en, irq}, 32'h0);
    endtask

    task automatic t_cfg;
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 mode keep", 8'h00, 32'h0000_1001);
        chk("R2 sync_mode", {31'b0, sync_mode}, 32'h1);
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R2 format keep", 8'h04, 32'h0000_330F);
        wr(8'h04, 32'h0000_2105);
        rd_chk("R2 format value", 8'h04, 32'h0000_2105);
        chk("R2 format fields", {24'b0, frm_bits, frm_par, frm_stop}, {24'b0, 4'h5, 2'd1, 2'd2});
        wr(8'h14, 32'hFFFF_FFFF);
        rd_chk("R2 div keep", 8'h14, 32'h001F_FFC0);
        chk("R2 baud_div max", {17'b0, baud_div}, 32'h7FFF);
        wr(8'h14, 32'h0000_1240);
        chk("R2 baud_div", {17'b0, baud_div}, 32'h49);
        wr(8'h54, 32'hFFFF_FFFF);
        rd_chk("R2 pin keep", 8'h54, 32'h0000_0703);
        wr(8'h54, 32'h0000_0502);
        chk("R2 pin fields", {27'b0, pin_loc, pin_tx_en, pin_rx_en}, {27'b0, 3'd5, 1'b1, 1'b0});
        wr(8'h00, 32'h0);
    endtask

    task automatic t_cmd;
        wr(8'h0C, 32'h1);
        chk("R3 rx start", {30'b0, rx_en, tx_en}, 32'h2);
        wr(8'h0C, 32'h4);
        chk("R3 tx start", {30'b0, rx_en, tx_en}, 32'h3);
        rd_chk("R4 status enables", 8'h10, 32'h3);
        wr(8'h0C, 32'h3);
        chk("R3 stop wins rx", {30'b0, rx_en, tx_en}, 32'h1);
        wr(8'h0C, 32'h8);
        chk("R3 tx stop", {30'b0, rx_en, tx_en}, 32'h0);
        wr(8'h0C, 32'h5);
        chk("R3 both start", {30'b0, rx_en, tx_en}, 32'h3);
        wr(8'h0C, 32'h0);
        chk("R3 zero no change", {30'b0, rx_en, tx_en}, 32'h3);
        rd_chk("R3 cmd reads zero", 8'h0C, 32'h0);
        wr(8'h0C, 32'hC);
        chk("R3 stop wins tx", {30'b0, rx_en, tx_en}, 32'h2);
        wr(8'h0C, 32'hA);
        chk("R3 both stop", {30'b0, rx_en, tx_en}, 32'h0);
    endtask

    task automatic t_status;
        tx_idle_i = 1; rx_avail_i = 1; tx_empty_i = 1; tx_half_i = 0;
        wr(8'h00, 32'h0);
        rd_chk("R4 status live", 8'h10, 32'h0000_00E0);
        wr(8'h00, 32'h0000_1000);
        rd_chk("R5 half select low", 8'h10, 32'h0000_00A0);
        tx_half_i = 1;
        rd_chk("R5 half select high", 8'h10, 32'h0000_00E0);
        tx_empty_i = 0;
        rd_chk("R5 empty ignored", 8'h10, 32'h0000_00E0);
        wr(8'h00, 32'h0);
        rd_chk("R5 empty select", 8'h10, 32'h0000_00A0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd_chk("R4 write ignored", 8'h10, 32'h0000_00A0);
        tx_idle_i = 0; rx_avail_i = 0; tx_half_i = 0;
        rd_chk("R4 status idle", 8'h10, 32'h0);
    endtask

    task automatic t_flags;
        @(negedge clk); tx_done_evt = 1;
        @(negedge clk); tx_done_evt = 0;
        rd_chk("R6 tx done set", 8'h40, 32'h01);
        repeat (3) @(negedge clk);
        rd_chk("R6 sticky", 8'h40, 32'h01);
        wr(8'h48, 32'h01);
        rd_chk("R7 clear", 8'h40, 32'h00);
        wr(8'h44, 32'h1F);
        rd_chk("R7 set sticky only", 8'h40, 32'h15);
        wr(8'h48, 32'h05);
        rd_chk("R7 partial clear", 8'h40, 32'h10);
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h48; bus_wdata = 32'h10; rx_ovf_evt = 1;
        @(negedge clk);
        bus_wr = 0; rx_ovf_evt = 0;
        rd_chk("R8 event beats clear", 8'h40, 32'h10);
        @(negedge clk); rx_got_evt = 1;
        @(negedge clk); rx_got_evt = 0;
        rd_chk("R6 rx data set", 8'h40, 32'h14);
        wr(8'h48, 32'hFFFF_FFFF);
        rd_chk("R7 clear all", 8'h40, 32'h00);
        tx_empty_i = 1;
        rd_chk("R9 level follows", 8'h40, 32'h02);
        wr(8'h48, 32'h02);
        rd_chk("R9 clear ignored", 8'h40, 32'h02);
        tx_empty_i = 0;
        rd_chk("R9 level drops", 8'h40, 32'h00);
        wr(8'h44, 32'h02);
        rd_chk("R9 set ignored", 8'h40, 32'h00);
    endtask

    task automatic t_irq;
        wr(8'h4C, 32'hFFFF_FFFF);
        rd_chk("R10 mask keep", 8'h4C, 32'h17);
        wr(8'h4C, 32'h0);
        wr(8'h44, 32'h04);
        chk("R10 masked off", {31'b0, irq}, 32'h0);
        wr(8'h4C, 32'h04);
        chk("R10 irq raised", {31'b0, irq}, 32'h1);
        wr(8'h4C, 32'h01);
        chk("R10 other mask bit", {31'b0, irq}, 32'h0);
        wr(8'h48, 32'h04);
        wr(8'h4C, 32'h02);
        @(negedge clk); tx_empty_i = 1;
        #1 chk("R10 live flag irq", {31'b0, irq}, 32'h1);
        tx_empty_i = 0;
        #1 chk("R10 live flag drop", {31'b0, irq}, 32'h0);
        wr(8'h4C, 32'h0);
    endtask

    task automatic t_undef;
        wr(8'h54, 32'h0000_0101);
        wr(8'h20, 32'hFFFF_FFFF);
        rd_chk("R11 undefined read", 8'h20, 32'h0);
        rd_chk("R11 gap read", 8'h08, 32'h0);
        rd_chk("R11 high read", 8'h5C, 32'h0);
        rd_chk("R11 pins untouched", 8'h54, 32'h0000_0101);
        rd_chk("R11 flags untouched", 8'h40, 32'h0);
        chk("R11 enables untouched", {30'b0, rx_en, tx_en}, 32'h0);
    endtask

    task automatic t_data;
        @(negedge clk);
        bus_wr = 1; bus_addr = 8'h34; bus_wdata = 32'hFFFF_F1A5;
        #1 chk("R12 tx_push high", {31'b0, tx_push}, 32'h1);
        chk("R12 tx_byte", {23'b0, tx_byte}, 32'h1A5);
        @(negedge clk);
        bus_wr = 0;
        #1 chk("R12 tx_push low", {31'b0, tx_push}, 32'h0);
        rx_word = 16'hC0DE;
        @(negedge clk);
        bus_addr = 8'h18; bus_rd = 1;
        #1 chk("R12 rx data", bus_rdata, 32'h0000_C0DE);
        chk("R12 rx_pop high", {31'b0, rx_pop}, 32'h1);
        bus_rd = 0;
        #1 chk("R12 rx_pop low", {31'b0, rx_pop}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_cfg;
        t_cmd;
        t_status;
        t_flags;
        t_irq;
        t_undef;
        t_data;
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule